// File: doc/BRIEF.md
# Memory Security Unlock Controller

This block keeps the security state that decides whether protected memory, such as on-chip RAM, may be reached from the debug port or from code that runs outside secure memory. While reset is held, it captures two 2-bit option fields: one gives the security state after reset and one enables or disables the key path. Security stays engaged until one of two unlock events takes place. The first is a key unlock: code running in secure memory writes an 8-byte comparison key one byte at a time, and the block compares it with a stored 64-bit key. The second is an erase unlock: the flash reports that a mass erase has completed, and a blank scan that follows finds every byte erased.

A key unlock lasts only until the next reset. A wrong key locks the key path until reset. The erase unlock can be used only when the key path is disabled. The block checks the flash read stream for the blank condition itself and turns the result into a one-cycle pass pulse. An access-grant output passes or blocks each request to protected memory according to its source tag and the present security state. Flash programming, the erase sequence and the debug protocol are outside this block. Only their handshake signals reach it.

Top module: `sec_unlock_ctrl`

## Requirements
- R1: The option fields are captured on every clock edge while `rst` is high. After reset, `mem_secure` is 0 when the captured `opt_sec` equals 2'b10 and 1 for any other value, and `key_lockout` is 0.
- R2: The key path is enabled only when the captured `opt_keyen` equals 2'b10. With any other value, key writes are ignored and a correct key causes no unlock.
- R3: A key byte is accepted only when `key_wr_src` is 2'b10 (secure code). Writes tagged 2'b00 (debug port), 2'b01 (non-secure code) or 2'b11 (reserved) are ignored and do not advance the byte position.
- R4: Accepted bytes fill the key in order: the first goes to `stored_key[7:0]` and the eighth to `stored_key[63:56]`. After the clock edge that takes the eighth byte, the next cycle is the compare cycle. On a match, `mem_secure` falls at the edge that ends the compare cycle, and it then stays low until reset.
- R5: On a mismatch, `key_lockout` rises at the edge that ends the compare cycle, `mem_secure` is unchanged, and all later key writes are ignored until reset.
- R6: A key unlock does not survive a reset. The next reset takes the state from `opt_sec` again.
- R7: With the key path disabled, an `erase_done` pulse followed by a blank scan whose bytes are all 8'hFF (the last byte marked by `blank_rd_last`) produces a pass pulse in the cycle after the last byte. `mem_secure` falls at the edge that ends that cycle.
- R8: No erase unlock occurs if the scan contains any byte other than 8'hFF, if no `erase_done` has come before the pass, or if the key path is enabled.
- R9: `acc_grant` is combinational: it is high only when `acc_req` is high and either `mem_secure` is 0 or `acc_src` is 2'b10. While secured, requests from source codes 2'b00, 2'b01 and 2'b11 are denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the option fields are sampled while it is high |
| opt_sec | input | 2 | Security option field (2'b10 = come out of reset unsecured) |
| opt_keyen | input | 2 | Key-path enable option field (2'b10 = enabled) |
| stored_key | input | 64 | Stored comparison key; byte 0 is bits [7:0] |
| key_wr_valid | input | 1 | Key byte write strobe |
| key_wr_src | input | 2 | Source tag of the key write (2'b10 = secure code) |
| key_wr_data | input | 8 | Key byte being written |
| erase_done | input | 1 | One-cycle pulse when a mass erase completes |
| blank_rd_valid | input | 1 | A byte of the blank scan is presented |
| blank_rd_data | input | 8 | Byte read back during the blank scan |
| blank_rd_last | input | 1 | Marks the final byte of the blank scan |
| acc_req | input | 1 | Request to protected memory |
| acc_src | input | 2 | Source tag of the request (00 debug, 01 non-secure, 10 secure) |
| acc_grant | output | 1 | Request is allowed |
| mem_secure | output | 1 | 1 while memory security is engaged |
| key_lockout | output | 1 | 1 after a wrong key, until reset |

## Verification
The assertions assume that the option fields stay steady during the last reset cycle. They also assume that `erase_done` and blank-scan bytes never arrive on the same cycle, and that key writes come as single-cycle strobes. The bench drives every input 2 ns after a rising edge, holds both option fields steady for two reset cycles, and separates the erase pulse, the scan bytes and the key writes by whole cycles. The source tags go through all four codes, including the reserved one, and scans appear both with and without a preceding erase, so that the ignore paths are exercised inside these assumptions.

// File: rtl/sec_unlock_pkg.sv
package sec_unlock_pkg;

    localparam int KEY_BYTES_DEF = 8;

    localparam logic [1:0] SEC_OPEN_CODE = 2'b10;
    localparam logic [1:0] KEY_ON_CODE   = 2'b10;
    localparam logic [7:0] ERASED_BYTE   = 8'hFF;

    typedef enum logic [1:0] {
        SRC_DEBUG  = 2'b00,
        SRC_NONSEC = 2'b01,
        SRC_SECURE = 2'b10,
        SRC_RSVD   = 2'b11
    } req_src_e;

    typedef struct packed {
        logic secure;
        logic key_en;
        logic lockout;
        logic erase_seen;
    } sec_state_t;

    function automatic logic src_is_secure(input logic [1:0] src);
        return src == SRC_SECURE;
    endfunction

    function automatic logic boot_secure(input logic [1:0] field);
        return field != SEC_OPEN_CODE;
    endfunction

    function automatic logic key_path_on(input logic [1:0] field);
        return field == KEY_ON_CODE;
    endfunction

endpackage

// File: rtl/sec_key_collect.sv
module sec_key_collect #(
    parameter int KEY_BYTES = 8,
    parameter int CNT_W     = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_ok,
    input  logic [7:0]             wr_data,
    input  logic [KEY_BYTES*8-1:0] ref_key,
    output logic                   busy,
    output logic [CNT_W-1:0]       cnt,
    output logic                   match,
    output logic                   mismatch
);
    localparam int KEY_W = KEY_BYTES * 8;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(KEY_BYTES - 1);

    logic [KEY_W-1:0] key_buf_q;
    logic [CNT_W-1:0] cnt_q;
    logic             pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            pend_q <= 1'b0;
            if (wr_ok) begin
                if (cnt_q == LAST_IDX) begin
                    cnt_q  <= '0;
                    pend_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    for (genvar g = 0; g < KEY_BYTES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                key_buf_q[g*8 +: 8] <= '0;
            end else if (wr_ok && cnt_q == CNT_W'(g)) begin
                key_buf_q[g*8 +: 8] <= wr_data;
            end
        end
    end

    assign busy     = pend_q;
    assign cnt      = cnt_q;
    assign match    = pend_q && (key_buf_q == ref_key);
    assign mismatch = pend_q && (key_buf_q != ref_key);

endmodule

// File: rtl/sec_blank_check.sv
module sec_blank_check
    import sec_unlock_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       erase_done,
    input  logic       rd_valid,
    input  logic [7:0] rd_data,
    input  logic       rd_last,
    output logic       pass
);
    logic clean_q;
    logic pass_q;
    logic byte_ok;

    assign byte_ok = (rd_data == ERASED_BYTE);

    always_ff @(posedge clk) begin
        if (rst) begin
            clean_q <= 1'b1;
            pass_q  <= 1'b0;
        end else begin
            pass_q <= 1'b0;
            if (erase_done) begin
                clean_q <= 1'b1;
            end else if (rd_valid) begin
                if (rd_last) begin
                    pass_q  <= clean_q && byte_ok;
                    clean_q <= 1'b1;
                end else begin
                    clean_q <= clean_q && byte_ok;
                end
            end
        end
    end

    assign pass = pass_q;

endmodule

// File: rtl/sec_access_gate.sv
module sec_access_gate
    import sec_unlock_pkg::*;
(
    input  logic       secure,
    input  logic       req,
    input  logic [1:0] src,
    output logic       grant
);
    always_comb begin
        grant = 1'b0;
        if (req) begin
            grant = !secure || src_is_secure(src);
        end
    end

endmodule

// File: rtl/sec_unlock_ctrl.sv
module sec_unlock_ctrl
    import sec_unlock_pkg::*;
#(
    parameter int KEY_BYTES = KEY_BYTES_DEF
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [1:0]             opt_sec,
    input  logic [1:0]             opt_keyen,
    input  logic [KEY_BYTES*8-1:0] stored_key,
    input  logic                   key_wr_valid,
    input  logic [1:0]             key_wr_src,
    input  logic [7:0]             key_wr_data,
    input  logic                   erase_done,
    input  logic                   blank_rd_valid,
    input  logic [7:0]             blank_rd_data,
    input  logic                   blank_rd_last,
    input  logic                   acc_req,
    input  logic [1:0]             acc_src,
    output logic                   acc_grant,
    output logic                   mem_secure,
    output logic                   key_lockout
);
    localparam int CNT_W = (KEY_BYTES > 1) ? $clog2(KEY_BYTES) : 1;

    sec_state_t       st_q;
    logic             key_wr_ok;
    logic             key_busy;
    logic [CNT_W-1:0] key_cnt;
    logic             key_match;
    logic             key_mismatch;
    logic             blank_pass;
    logic             erase_unlock;
    logic             key_en;

    assign key_en    = st_q.key_en;
    assign key_wr_ok = key_wr_valid && src_is_secure(key_wr_src) && st_q.key_en
                       && !st_q.lockout && st_q.secure && !key_busy;

    sec_key_collect #(
        .KEY_BYTES (KEY_BYTES),
        .CNT_W     (CNT_W)
    ) u_key (
        .clk      (clk),
        .rst      (rst),
        .wr_ok    (key_wr_ok),
        .wr_data  (key_wr_data),
        .ref_key  (stored_key),
        .busy     (key_busy),
        .cnt      (key_cnt),
        .match    (key_match),
        .mismatch (key_mismatch)
    );

    sec_blank_check u_blank (
        .clk        (clk),
        .rst        (rst),
        .erase_done (erase_done),
        .rd_valid   (blank_rd_valid),
        .rd_data    (blank_rd_data),
        .rd_last    (blank_rd_last),
        .pass       (blank_pass)
    );

    assign erase_unlock = blank_pass && st_q.erase_seen && !st_q.key_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.secure     <= boot_secure(opt_sec);
            st_q.key_en     <= key_path_on(opt_keyen);
            st_q.lockout    <= 1'b0;
            st_q.erase_seen <= 1'b0;
        end else begin
            if (key_match || erase_unlock) begin
                st_q.secure <= 1'b0;
            end
            if (key_mismatch) begin
                st_q.lockout <= 1'b1;
            end
            if (erase_done && !st_q.key_en) begin
                st_q.erase_seen <= 1'b1;
            end
        end
    end

    sec_access_gate u_gate (
        .secure (st_q.secure),
        .req    (acc_req),
        .src    (acc_src),
        .grant  (acc_grant)
    );

    assign mem_secure  = st_q.secure;
    assign key_lockout = st_q.lockout;

endmodule

// File: rtl/sec_unlock_chk.sv
module sec_unlock_chk
    import sec_unlock_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       opt_sec,
    input logic             key_wr_valid,
    input logic [1:0]       key_wr_src,
    input logic             acc_req,
    input logic [1:0]       acc_src,
    input logic             acc_grant,
    input logic             mem_secure,
    input logic             key_lockout,
    input logic             key_en,
    input logic             key_match,
    input logic [CNT_W-1:0] key_cnt
);
    // R1: state right after reset follows the captured option field
    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (mem_secure == ($past(opt_sec) != 2'b10)) && !key_lockout);

    // R2: no key match is ever reported with the key path disabled
    p_key_disabled_r2: assert property (@(posedge clk) disable iff (rst)
        !key_en |-> !key_match);

    // R3: writes not tagged secure leave the byte position alone
    p_src_ignored_r3: assert property (@(posedge clk) disable iff (rst)
        (key_wr_valid && key_wr_src != SRC_SECURE) |=> $stable(key_cnt));

    // R4: once released, security stays released until reset
    p_unlock_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        !mem_secure |=> !mem_secure);

    // R5: lockout holds and blocks any further match
    p_lockout_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        key_lockout |=> key_lockout);

    p_lockout_blocks_r5: assert property (@(posedge clk) disable iff (rst)
        key_lockout |-> !key_match);

    // R9: access gating
    p_grant_secure_r9: assert property (@(posedge clk) disable iff (rst)
        (acc_req && acc_src == SRC_SECURE) |-> acc_grant);

    p_deny_secured_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_secure && acc_src != SRC_SECURE) |-> !acc_grant);

    p_no_req_r9: assert property (@(posedge clk) disable iff (rst)
        !acc_req |-> !acc_grant);

endmodule

bind sec_unlock_ctrl sec_unlock_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .opt_sec      (opt_sec),
    .key_wr_valid (key_wr_valid),
    .key_wr_src   (key_wr_src),
    .acc_req      (acc_req),
    .acc_src      (acc_src),
    .acc_grant    (acc_grant),
    .mem_secure   (mem_secure),
    .key_lockout  (key_lockout),
    .key_en       (key_en),
    .key_match    (key_match),
    .key_cnt      (key_cnt)
);

// File: tb/sec_unlock_ctrl_tb.sv
module sec_unlock_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  opt_sec = 2'b00;
    logic [1:0]  opt_keyen = 2'b10;
    logic [63:0] stored_key = 64'h0;
    logic        key_wr_valid = 1'b0;
    logic [1:0]  key_wr_src = 2'b00;
    logic [7:0]  key_wr_data = 8'h00;
    logic        erase_done = 1'b0;
    logic        blank_rd_valid = 1'b0;
    logic [7:0]  blank_rd_data = 8'h00;
    logic        blank_rd_last = 1'b0;
    logic        acc_req = 1'b0;
    logic [1:0]  acc_src = 2'b00;
    logic        acc_grant;
    logic        mem_secure;
    logic        key_lockout;

    int n_chk = 0;
    int n_bad = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    always #10 clk = ~clk;

    sec_unlock_ctrl u_dut (
        .clk            (clk),
        .rst            (rst),
        .opt_sec        (opt_sec),
        .opt_keyen      (opt_keyen),
        .stored_key     (stored_key),
        .key_wr_valid   (key_wr_valid),
        .key_wr_src     (key_wr_src),
        .key_wr_data    (key_wr_data),
        .erase_done     (erase_done),
        .blank_rd_valid (blank_rd_valid),
        .blank_rd_data  (blank_rd_data),
        .blank_rd_last  (blank_rd_last),
        .acc_req        (acc_req),
        .acc_src        (acc_src),
        .acc_grant      (acc_grant),
        .mem_secure     (mem_secure),
        .key_lockout    (key_lockout)
    );

    // ---------------- behavioural reference model ----------------
    bit         m_sec = 1'b1;
    bit         m_keyon = 1'b0;
    bit         m_lock = 1'b0;
    bit         m_pend = 1'b0;
    bit         m_erased = 1'b0;
    bit         m_clean = 1'b1;
    bit         m_pass = 1'b0;
    bit [63:0]  m_key = 64'h0;
    logic [7:0] m_bytes[$];

    always @(posedge clk) begin
        if (rst) begin
            m_sec = (opt_sec != 2'b10);
            m_keyon = (opt_keyen == 2'b10);
            m_lock = 1'b0;
            m_pend = 1'b0;
            m_erased = 1'b0;
            m_clean = 1'b1;
            m_pass = 1'b0;
            m_bytes.delete();
        end else begin
            bit take;
            bit n_sec;
            bit n_pend;
            bit n_pass;
            take = key_wr_valid && key_wr_src == 2'b10 && m_keyon && !m_lock
                   && m_sec && !m_pend;
            n_sec = m_sec;
            n_pend = 1'b0;
            if (m_pend) begin
                if (m_key == stored_key) n_sec = 1'b0;
                else m_lock = 1'b1;
            end
            if (m_pass && m_erased && !m_keyon) n_sec = 1'b0;
            n_pass = 1'b0;
            if (erase_done) begin
                m_clean = 1'b1;
            end else if (blank_rd_valid) begin
                if (blank_rd_last) begin
                    n_pass = m_clean && blank_rd_data == 8'hFF;
                    m_clean = 1'b1;
                end else begin
                    m_clean = m_clean && blank_rd_data == 8'hFF;
                end
            end
            if (erase_done && !m_keyon) m_erased = 1'b1;
            if (take) begin
                m_bytes.push_back(key_wr_data);
                if (m_bytes.size() == 8) begin
                    for (int i = 0; i < 8; i++) m_key[i*8 +: 8] = m_bytes[i];
                    m_bytes.delete();
                    n_pend = 1'b1;
                end
            end
            m_sec = n_sec;
            m_pend = n_pend;
            m_pass = n_pass;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            bit m_grant;
            m_grant = acc_req && (!m_sec || acc_src == 2'b10);
            check(cur_req, "mem_secure vs model", {7'd0, mem_secure}, {7'd0, m_sec});
            check(cur_req, "key_lockout vs model", {7'd0, key_lockout}, {7'd0, m_lock});
            check(cur_req, "acc_grant vs model", {7'd0, acc_grant}, {7'd0, m_grant});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset(input logic [1:0] s, input logic [1:0] k);
        rst = 1'b1;
        opt_sec = s;
        opt_keyen = k;
        cyc();
        cyc();
        rst = 1'b0;
        cyc();
    endtask

    task automatic wr_byte(input logic [1:0] src, input logic [7:0] d);
        key_wr_valid = 1'b1;
        key_wr_src = src;
        key_wr_data = d;
        cyc();
        key_wr_valid = 1'b0;
    endtask

    task automatic wr_key(input logic [1:0] src, input logic [63:0] k);
        for (int i = 0; i < 8; i++) wr_byte(src, k[i*8 +: 8]);
    endtask

    task automatic pulse_erase();
        erase_done = 1'b1;
        cyc();
        erase_done = 1'b0;
    endtask

    task automatic scan(input int n, input int bad_idx);
        for (int i = 0; i < n; i++) begin
            blank_rd_valid = 1'b1;
            blank_rd_data = (i == bad_idx) ? 8'h00 : 8'hFF;
            blank_rd_last = (i == n - 1);
            cyc();
        end
        blank_rd_valid = 1'b0;
        blank_rd_last = 1'b0;
    endtask

    task automatic probe(input string req, input logic [1:0] src, input logic exp);
        acc_req = 1'b1;
        acc_src = src;
        #1;
        check(req, "acc_grant probe", {7'd0, acc_grant}, {7'd0, exp});
        cyc();
        acc_req = 1'b0;
    endtask

    localparam logic [63:0] GOOD_KEY = 64'h8877_6655_4433_2211;

    initial begin
        stored_key = GOOD_KEY;

        // R1 / R9: secured after reset, gating by source
        cur_req = "R1";
        do_reset(2'b00, 2'b10);
        check("R1", "secured after reset", {7'd0, mem_secure}, 8'd1);
        check("R1", "no lockout after reset", {7'd0, key_lockout}, 8'd0);
        cur_req = "R9";
        probe("R9", 2'b00, 1'b0);
        probe("R9", 2'b01, 1'b0);
        probe("R9", 2'b11, 1'b0);
        probe("R9", 2'b10, 1'b1);

        // R3: debug, non-secure and reserved tags ignored
        cur_req = "R3";
        wr_key(2'b00, GOOD_KEY);
        wr_key(2'b01, GOOD_KEY);
        wr_key(2'b11, GOOD_KEY);
        cyc();
        cyc();
        check("R3", "untrusted key writes ignored", {7'd0, mem_secure}, 8'd1);

        // R4: byte order and unlock timing; partial non-secure write in between
        cur_req = "R4";
        for (int i = 0; i < 4; i++) wr_byte(2'b10, GOOD_KEY[i*8 +: 8]);
        wr_byte(2'b00, 8'hEE);
        for (int i = 4; i < 8; i++) wr_byte(2'b10, GOOD_KEY[i*8 +: 8]);
        check("R4", "still secured in compare cycle", {7'd0, mem_secure}, 8'd1);
        cyc();
        check("R4", "unlocked after compare", {7'd0, mem_secure}, 8'd0);
        probe("R9", 2'b00, 1'b1);
        probe("R9", 2'b01, 1'b1);

        // R6: unlock lost at reset
        cur_req = "R6";
        do_reset(2'b01, 2'b10);
        check("R6", "secured again after reset", {7'd0, mem_secure}, 8'd1);

        // R5: wrong key (byte order swapped) locks out
        cur_req = "R5";
        wr_key(2'b10, {GOOD_KEY[7:0], GOOD_KEY[63:8]});
        cyc();
        check("R5", "lockout after wrong key", {7'd0, key_lockout}, 8'd1);
        check("R5", "still secured after wrong key", {7'd0, mem_secure}, 8'd1);
        wr_key(2'b10, GOOD_KEY);
        cyc();
        cyc();
        check("R5", "correct key ignored in lockout", {7'd0, mem_secure}, 8'd1);

        // R1: open security code
        cur_req = "R1";
        do_reset(2'b10, 2'b10);
        check("R1", "unsecured with open code", {7'd0, mem_secure}, 8'd0);
        probe("R9", 2'b00, 1'b1);

        // R2: key path disabled
        cur_req = "R2";
        do_reset(2'b11, 2'b01);
        wr_key(2'b10, GOOD_KEY);
        cyc();
        cyc();
        check("R2", "key ignored when disabled", {7'd0, mem_secure}, 8'd1);

        // R8: scan without erase, scan with a dirty byte
        cur_req = "R8";
        scan(6, -1);
        cyc();
        check("R8", "scan without erase ignored", {7'd0, mem_secure}, 8'd1);
        pulse_erase();
        scan(6, 3);
        cyc();
        check("R8", "dirty scan ignored", {7'd0, mem_secure}, 8'd1);

        // R7: erase then clean scan releases security
        cur_req = "R7";
        scan(5, -1);
        check("R7", "secured in pass cycle", {7'd0, mem_secure}, 8'd1);
        cyc();
        check("R7", "unlocked after clean scan", {7'd0, mem_secure}, 8'd0);

        // R2: key-enable code 2'b00 also disables
        cur_req = "R2";
        do_reset(2'b00, 2'b00);
        wr_key(2'b10, GOOD_KEY);
        cyc();
        cyc();
        check("R2", "key ignored with 2'b00", {7'd0, mem_secure}, 8'd1);

        // R8: erase path ignored with key enabled
        cur_req = "R8";
        do_reset(2'b00, 2'b10);
        pulse_erase();
        scan(4, -1);
        cyc();
        cyc();
        check("R8", "erase ignored with key on", {7'd0, mem_secure}, 8'd1);
        // key still usable afterwards
        cur_req = "R4";
        wr_key(2'b10, GOOD_KEY);
        cyc();
        check("R4", "key unlock after erase attempt", {7'd0, mem_secure}, 8'd0);

        cyc();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL %s watchdog: actual=%0d expected=%0d", cur_req, 20000, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule